// File: doc/BRIEF.md
# Direct-Mapped Line-Fill Cache

This block sits between a processor core and a slow external memory that can return data in bursts. Every processor access is looked up in a direct-mapped array of 512 lines. A read that hits returns its bytes in the same cycle it is presented, with `cpu_ready` high. A read that misses holds `cpu_ready` low and fetches the whole 16-byte line as one burst. The line is written into storage and the access then completes as a hit. Each storage entry holds the 128-bit line and its 16-bit tag together in one 144-bit word. One lookup therefore yields both, and a lane steerer cuts the requested 8, 16 or 32 bits out of the line.

Writes go through to memory and do not allocate. A write that hits also updates the matching bytes of the cached line. Every write holds `cpu_ready` low until memory acknowledges it. The processor must hold its request fields stable while `cpu_ready` is low. Halfword and word accesses must be naturally aligned.

Top module: `dm_line_cache`

## Requirements
- R1: The byte address is split as tag = addr[28:13], line index = addr[12:4] and offset = addr[3:0]. Two addresses with the same index and different tags evict each other, while lines at other indices stay resident.
- R2: A read that hits has `cpu_ready` high in the same cycle it is presented, with correct `cpu_rdata` and no memory request.
- R3: A read that misses keeps `cpu_ready` low. In the cycle after the request, it pulses `mem_rd_req` for exactly one cycle with `mem_rd_addr` line-aligned (offset bits zero). It accepts 8 beats of 16 bits, where beat j carries line byte 2j in bits [7:0] and byte 2j+1 in bits [15:8]. `cpu_ready` rises with the correct data in the cycle after the cycle that delivers the last beat.
- R4: `cpu_size` selects the access width: 0 = byte, 1 = halfword, 2 = word. Data is little-endian, so line byte k sits at line bits [8k+7:8k]. A read returns the bytes starting at the offset, zero-extended in the upper bits of `cpu_rdata`.
- R5: Reset clears every valid bit, so the first read of any line after reset misses.
- R6: Every write raises `mem_wr_req` in the cycle after the request. `mem_wr_req` stays high, with `mem_wr_addr`, `mem_wr_size` and `mem_wr_data` equal to the processor's fields, until `mem_wr_ack`. `cpu_ready` is high in the cycle `mem_wr_ack` is high, and memory then holds the written bytes.
- R7: A write that hits updates the written bytes of the cached line, so a later read hit returns the new value.
- R8: A write that misses does not load the line, so a later read of that line misses and returns the written value from memory.
- R9: While reset is held and with no request, `cpu_ready` is high and both `mem_rd_req` and `mem_wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access width code (0 byte, 1 half, 2 word) |
| cpu_addr | input | 29 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdata | output | 32 | Read data, right-aligned, zero-extended |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_rd_req | output | 1 | One-cycle line burst request |
| mem_rd_addr | output | 29 | Line-aligned burst address |
| mem_rd_valid | input | 1 | Burst beat present |
| mem_rd_data | input | 16 | Burst beat data |
| mem_wr_req | output | 1 | Write-through request, held until acknowledged |
| mem_wr_addr | output | 29 | Write byte address |
| mem_wr_size | output | 2 | Write width code |
| mem_wr_data | output | 32 | Write data, right-aligned |
| mem_wr_ack | input | 1 | Memory accepts the write |

## Verification
A read hit is due in the presentation cycle. The memory model in the bench answers a burst request one cycle after seeing it and then sends one beat per cycle. With that model a read miss completes exactly ten cycles after presentation. A write completes two cycles after presentation, in the cycle the model raises its acknowledge. The bench drives inputs on the falling edge and samples `cpu_ready` just after it. It counts whole cycles until ready and compares that count to 0, 2 or 10, and it compares the captured data against a byte-level shadow of memory.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped line-fill cache.
// Assumes: size code 3 is reserved and treated as a word access.
package dmc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_BEAT,
        ST_WRITE
    } ctl_state_t;
endpackage

// File: rtl/dmc_line_store.sv
// Line storage: each entry is {tag, line} in one word, plus a separate
// valid-bit array that reset clears. Reads are combinational so a hit
// completes in the cycle it is looked up.
// Assumes: fill and merge never target the entry in the same cycle.
module dmc_line_store #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 16,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              merge_en,
    input  logic [LINE_W/8-1:0] merge_be,
    input  logic [LINE_W-1:0] merge_line
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = TAG_W + LINE_W;
    localparam int LANES = LINE_W / 8;

    logic [ENT_W-1:0] ent [DEPTH];
    logic [DEPTH-1:0] valid_q;

    // Lookup of the addressed entry
    assign rd_tag   = ent[idx][ENT_W-1 -: TAG_W];
    assign rd_line  = ent[idx][LINE_W-1:0];
    assign rd_valid = valid_q[idx];

    // Entry write: whole line on fill, selected bytes on write merge
    always_ff @(posedge clk) begin
        if (fill_en) begin
            ent[idx] <= {fill_tag, fill_line};
        end else if (merge_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (merge_be[b]) ent[idx][b*8 +: 8] <= merge_line[b*8 +: 8];
            end
        end
    end

    // Valid bits: cleared by reset, set by a completed fill
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (fill_en) valid_q[idx] <= 1'b1;
    end

    // R5
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(idx)]);
endmodule

// File: rtl/dmc_lane_steer.sv
// Lane steering between a full line and the processor port: extracts the
// addressed bytes for reads, and builds byte enables plus a replicated
// write line for merges.
// Assumes: half and word accesses are naturally aligned.
module dmc_lane_steer
    import dmc_pkg::*;
#(
    parameter int LINE_W = 128,
    parameter int OFF_W  = 4,
    parameter int CPU_W  = 32
) (
    input  logic [LINE_W-1:0]   line,
    input  logic [OFF_W-1:0]    offset,
    input  acc_size_t           size,
    input  logic [CPU_W-1:0]    wdata,
    output logic [CPU_W-1:0]    rdata,
    output logic [LINE_W/8-1:0] be,
    output logic [LINE_W-1:0]   wline
);
    localparam int LANES = LINE_W / 8;

    logic [LINE_W-1:0] shifted;
    logic [LANES-1:0]  base_be;

    // Bring the addressed byte down to bit 0
    assign shifted = line >> {offset, 3'b000};

    // Read extraction with zero extension
    always_comb begin
        case (size)
            SZ_BYTE: rdata = CPU_W'(shifted[7:0]);
            SZ_HALF: rdata = CPU_W'(shifted[15:0]);
            default: rdata = shifted[CPU_W-1:0];
        endcase
    end

    // Byte enables and write data replicated across every lane
    always_comb begin
        case (size)
            SZ_BYTE: begin
                base_be = LANES'(1);
                wline   = {LANES{wdata[7:0]}};
            end
            SZ_HALF: begin
                base_be = LANES'(3);
                wline   = {(LANES/2){wdata[15:0]}};
            end
            default: begin
                base_be = LANES'({(CPU_W/8){1'b1}});
                wline   = {(LINE_W/CPU_W){wdata}};
            end
        endcase
        be = base_be << offset;
    end
endmodule

// File: rtl/dmc_fill_ctrl.sv
// Control sequencer: decides ready, issues the burst request on a read
// miss, gathers beats into a line, and holds write-through requests until
// memory acknowledges them.
// Assumes: the processor holds its request stable while ready is low.
module dmc_fill_ctrl
    import dmc_pkg::*;
#(
    parameter int LINE_W = 128,
    parameter int BEAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [BEAT_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    input  logic              mem_wr_ack,
    output logic              fill_en,
    output logic [LINE_W-1:0] fill_line,
    output logic              merge_en
);
    localparam int BEATS = LINE_W / BEAT_W;
    localparam int CNT_W = $clog2(BEATS);

    ctl_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [LINE_W-1:0] lbuf;
    logic              last_beat;

    assign last_beat = (cnt == CNT_W'(BEATS - 1));

    // Next-state decision
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (cpu_req && cpu_we)    nxt = ST_WRITE;
                      else if (cpu_req && !hit) nxt = ST_REQ;
            ST_REQ:   nxt = ST_BEAT;
            ST_BEAT:  if (mem_rd_valid && last_beat) nxt = ST_IDLE;
            ST_WRITE: if (mem_wr_ack) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Beat counter, restarted when the burst is requested
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (state == ST_REQ)               cnt <= '0;
        else if (state == ST_BEAT && mem_rd_valid) cnt <= cnt + 1'b1;
    end

    // Beat gathering into the line buffer
    always_ff @(posedge clk) begin
        if (state == ST_BEAT && mem_rd_valid) lbuf[cnt*BEAT_W +: BEAT_W] <= mem_rd_data;
    end

    // Completed line: gathered beats with the final beat taken directly
    always_comb begin
        fill_line = lbuf;
        fill_line[LINE_W-BEAT_W +: BEAT_W] = mem_rd_data;
    end

    // Outputs derived from state and responses
    assign fill_en    = (state == ST_BEAT) && mem_rd_valid && last_beat;
    assign mem_rd_req = (state == ST_REQ);
    assign mem_wr_req = (state == ST_WRITE);
    assign merge_en   = (state == ST_WRITE) && mem_wr_ack && hit;
    assign cpu_ready  = ((state == ST_IDLE) && (!cpu_req || (!cpu_we && hit)))
                      || ((state == ST_WRITE) && mem_wr_ack);

    // R3
    rd_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req);
endmodule

// File: rtl/dm_line_cache.sv
// Direct-mapped line-fill cache top: splits the address, compares the
// stored tag, and ties storage, steering and the control sequencer together.
// Assumes: aligned accesses, request held stable while ready is low.
module dm_line_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 4,
    parameter int BEAT_W = 16,
    parameter int CPU_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CPU_W-1:0]  cpu_wdata,
    output logic [CPU_W-1:0]  cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [BEAT_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [1:0]        mem_wr_size,
    output logic [CPU_W-1:0]  mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int LINE_W = (1 << OFF_W) * 8;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LANES  = LINE_W / 8;

    logic [TAG_W-1:0]  a_tag, st_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic [LINE_W-1:0] st_line, fill_line, merge_line;
    logic [LANES-1:0]  merge_be;
    logic              st_valid, lookup_hit, fill_en, merge_en;
    acc_size_t         a_size;

    // Address field split
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_off  = cpu_addr[OFF_W-1:0];
    assign a_size = acc_size_t'(cpu_size);

    // Tag compare against the entry read in the same lookup
    assign lookup_hit = st_valid && (st_tag == a_tag);

    // Memory-side address and write fields
    assign mem_rd_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wr_addr = cpu_addr;
    assign mem_wr_size = cpu_size;
    assign mem_wr_data = cpu_wdata;

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (a_idx),
        .rd_tag     (st_tag),
        .rd_line    (st_line),
        .rd_valid   (st_valid),
        .fill_en    (fill_en),
        .fill_tag   (a_tag),
        .fill_line  (fill_line),
        .merge_en   (merge_en),
        .merge_be   (merge_be),
        .merge_line (merge_line)
    );

    dmc_lane_steer #(.LINE_W(LINE_W), .OFF_W(OFF_W), .CPU_W(CPU_W)) u_steer (
        .line   (st_line),
        .offset (a_off),
        .size   (a_size),
        .wdata  (cpu_wdata),
        .rdata  (cpu_rdata),
        .be     (merge_be),
        .wline  (merge_line)
    );

    dmc_fill_ctrl #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit          (lookup_hit),
        .cpu_ready    (cpu_ready),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_ack   (mem_wr_ack),
        .fill_en      (fill_en),
        .fill_line    (fill_line),
        .merge_en     (merge_en)
    );

    // R3
    fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> lookup_hit);
    // R6
    wr_ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |-> mem_wr_ack);
endmodule

// File: tb/dm_line_cache_test.sv
module dm_line_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [28:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_rd_req;
    logic [28:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [28:0] mem_wr_addr;
    logic [1:0]  mem_wr_size;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;

    int checks = 0, fails = 0;
    logic [7:0]  mem [512];
    logic [7:0]  shadow [512];
    logic [28:0] last_rd_addr = '0;

    always #10 clk = ~clk;

    dm_line_cache uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_size(mem_wr_size), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    // Small test window: tag 0..3, index 0..7 folded into 512 bytes
    function automatic int bidx(input logic [28:0] a);
        return int'({a[14:13], a[6:4], a[3:0]});
    endfunction

    function automatic logic [28:0] mk(input int tag, input int idx, input int off);
        return 29'((tag << 13) | (idx << 4) | off);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [28:0] a);
        int i = bidx(a);
        case (sz)
            2'd0:    return {24'b0, shadow[i]};
            2'd1:    return {16'b0, shadow[i+1], shadow[i]};
            default: return {shadow[i+3], shadow[i+2], shadow[i+1], shadow[i]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Burst read model: one cycle after the request, eight beats, one per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                last_rd_addr = mem_rd_addr;
                for (int j = 0; j < 8; j++) begin
                    @(negedge clk);
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = {mem[bidx(last_rd_addr) + 2*j + 1], mem[bidx(last_rd_addr) + 2*j]};
                end
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    // Write model: acknowledge one cycle after seeing the request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_wr_req) begin
                @(negedge clk);
                mem_wr_ack = 1'b1;
                for (int k = 0; k < (mem_wr_size == 2'd0 ? 1 : mem_wr_size == 2'd1 ? 2 : 4); k++)
                    mem[bidx(mem_wr_addr) + k] = mem_wr_data[k*8 +: 8];
                @(negedge clk);
                mem_wr_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic we, input logic [1:0] sz, input logic [28:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = cpu_rdata;
        if (we) begin
            for (int k = 0; k < (sz == 2'd0 ? 1 : sz == 2'd1 ? 2 : 4); k++)
                shadow[bidx(a) + k] = wd[k*8 +: 8];
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R9 idle outputs while reset is held
        check("R9 ready", {31'b0, cpu_ready}, 32'd1);
        check("R9 rd_req", {31'b0, mem_rd_req}, 32'd0);
        check("R9 wr_req", {31'b0, mem_wr_req}, 32'd0);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 29 + 7) & 255);
            shadow[i] = mem[i];
        end
        do_reset();

        // R3 first read is a miss with burst timing and an aligned address
        access(1'b0, 2'd2, mk(0, 0, 8), '0, rd, cyc);
        check("R3 miss cycles", 32'(cyc), 32'd10);
        check("R3 line aligned burst addr", {3'b0, last_rd_addr}, {3'b0, mk(0, 0, 0)});
        check("R4 word after fill", rd, exp_rd(2'd2, mk(0, 0, 8)));

        // R2 R4 sweep every size and aligned offset of the filled line
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 16; off += (1 << sz)) begin
                access(1'b0, 2'(sz), mk(0, 0, off), '0, rd, cyc);
                check("R2 hit cycles", 32'(cyc), 32'd0);
                check("R4 steered data", rd, exp_rd(2'(sz), mk(0, 0, off)));
            end
        end

        // R1 fill other indices, then reread as hits
        for (int idx = 1; idx < 8; idx++) begin
            access(1'b0, 2'd2, mk(0, idx, 4), '0, rd, cyc);
            check("R1 index miss", 32'(cyc), 32'd10);
            check("R1 index data", rd, exp_rd(2'd2, mk(0, idx, 4)));
            access(1'b0, 2'd1, mk(0, idx, 14), '0, rd, cyc);
            check("R1 index hit", 32'(cyc), 32'd0);
            check("R1 index hit data", rd, exp_rd(2'd1, mk(0, idx, 14)));
        end

        // R1 conflicting tags evict each other; neighbours stay resident
        access(1'b0, 2'd2, mk(1, 3, 0), '0, rd, cyc);
        check("R1 conflict miss", 32'(cyc), 32'd10);
        check("R1 conflict data", rd, exp_rd(2'd2, mk(1, 3, 0)));
        access(1'b0, 2'd2, mk(0, 3, 0), '0, rd, cyc);
        check("R1 evicted miss", 32'(cyc), 32'd10);
        access(1'b0, 2'd0, mk(0, 2, 9), '0, rd, cyc);
        check("R1 neighbour hit", 32'(cyc), 32'd0);

        // R6 R7 write hits of each size
        access(1'b1, 2'd0, mk(0, 2, 5), 32'h0000_00A5, rd, cyc);
        check("R6 write cycles", 32'(cyc), 32'd2);
        check("R6 memory byte", {24'b0, mem[bidx(mk(0, 2, 5))]}, 32'h0000_00A5);
        access(1'b0, 2'd0, mk(0, 2, 5), '0, rd, cyc);
        check("R7 byte hit", 32'(cyc), 32'd0);
        check("R7 byte data", rd, 32'h0000_00A5);
        access(1'b1, 2'd1, mk(0, 2, 10), 32'h0000_BEEF, rd, cyc);
        check("R6 half write cycles", 32'(cyc), 32'd2);
        access(1'b1, 2'd2, mk(0, 2, 12), 32'h1234_5678, rd, cyc);
        check("R6 word write cycles", 32'(cyc), 32'd2);
        access(1'b0, 2'd2, mk(0, 2, 12), '0, rd, cyc);
        check("R7 word hit", 32'(cyc), 32'd0);
        check("R7 word data", rd, 32'h1234_5678);
        access(1'b0, 2'd2, mk(0, 2, 8), '0, rd, cyc);
        check("R7 half merged", rd, exp_rd(2'd2, mk(0, 2, 8)));
        access(1'b0, 2'd2, mk(0, 2, 4), '0, rd, cyc);
        check("R7 byte merged", rd, exp_rd(2'd2, mk(0, 2, 4)));
        for (int i = 0; i < 512; i++) begin
            if (mem[i] !== shadow[i]) check("R6 memory image", {24'b0, mem[i]}, {24'b0, shadow[i]});
        end
        checks++;

        // R8 write miss does not allocate
        access(1'b1, 2'd2, mk(2, 5, 4), 32'hCAFE_F00D, rd, cyc);
        check("R8 write cycles", 32'(cyc), 32'd2);
        access(1'b0, 2'd2, mk(2, 5, 4), '0, rd, cyc);
        check("R8 read misses", 32'(cyc), 32'd10);
        check("R8 data from memory", rd, 32'hCAFE_F00D);

        // R5 reset invalidates every line
        do_reset();
        access(1'b0, 2'd2, mk(0, 2, 12), '0, rd, cyc);
        check("R5 miss after reset", 32'(cyc), 32'd10);
        check("R5 data after reset", rd, 32'h1234_5678);
        access(1'b0, 2'd2, mk(0, 0, 0), '0, rd, cyc);
        check("R5 other line misses", 32'(cyc), 32'd10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule